// File: doc/BRIEF.md
# Out-of-Order ALU Core with Reorder Buffer

This block is a small execution core for register-to-register ALU instructions. It takes instructions in program order from an instruction stream that sits next to a program counter. Each instruction is decoded and given the slot at the tail of a circular reorder buffer. Two identical fixed-latency ALU units take ready instructions out of program order, always serving the oldest ready entries first. A finished result is written into its own reorder-buffer entry and is broadcast to every entry that still waits on it. The entry at the head of the buffer retires once its result is present. Retiring writes the result into the architectural register file and reports the event on the retire pins.

The program counter `pc` addresses an instruction memory that lives outside the block. The memory returns the word at `pc` on `in_instr` together with `in_valid`. An instruction is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on how full the buffer is, never on `in_valid`. The source may hold `in_valid` low for any number of cycles, and must keep `in_instr` stable while a word is offered but not yet taken. Nothing is speculative: the core never redirects `pc` and never discards an instruction it has accepted.

Top module: `ooo_core`

## Requirements
- R1: After reset, `pc` is 0, all registers read 0, `retire_valid` is 0 and `in_ready` is 1.
- R2: An instruction is accepted only on an edge where `in_valid` and `in_ready` are both high, and `pc` then advances by one. `in_ready` is low exactly while DEPTH entries are occupied. A retirement frees a slot, and a waiting instruction is accepted in the following cycle.
- R3: Instruction word (16 bits): bits [15:13] opcode, [12:10] destination, [9:7] first source, [6:4] second source. Opcodes: 0 add, 1 subtract (first minus second), 2 and, 3 or, 4 xor, 5 shift left (first shifted by the low 4 bits of the second), 6 logical shift right (same shift amount), 7 load immediate (destination gets bits [9:0] zero-extended). Data is 16 bits wide and there are 8 registers.
- R4: Instructions retire one per cycle at most and strictly in program order. `retire_rd` and `retire_data` report the register written in that same cycle.
- R5: Register results equal those of sequential execution of the program. A source reads the youngest older instruction that writes that register, or the register file if there is none. A younger independent instruction may execute before an older dependent one.
- R6: A consumer that is accepted in the same cycle that its producer's result is written back receives the correct value.
- R7: An independent instruction accepted into an idle core in cycle c is reported as retiring in cycle c+LAT+2.
- R8: Two independent instructions accepted in consecutive cycles c and c+1 into an idle core execute concurrently on the two units and retire in cycles c+LAT+2 and c+LAT+3.
- R9: Issue goes oldest first. When both units are free, the oldest ready entry goes to unit 0 and the next oldest to unit 1. A burst of four independent instructions accepted in cycles c to c+3 into an idle core retires in cycles c+LAT+2, c+LAT+3, c+2*LAT+2 and c+2*LAT+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word at `pc` is present |
| in_ready | output | 1 | Reorder buffer has a free slot |
| in_instr | input | 16 | Instruction word |
| pc | output | PC_W (8) | Address of the next instruction to accept |
| retire_valid | output | 1 | Head entry retires this cycle |
| retire_rd | output | 3 | Register written by the retiring entry |
| retire_data | output | 16 | Value written by the retiring entry |
| regs_flat | output | 128 | Architectural registers; register r occupies bits [16r+15:16r] |

## Verification
Two things can fall in the same cycle and interact: the write-back broadcast of a producer's result, and the decode of a new instruction that reads that result. A decode that misses this case leaves the consumer waiting on a tag that will never be broadcast again. The bench provokes the collision by accepting a producer and then holding `in_valid` low for a swept number of cycles before offering the consumer. One of these gaps lands exactly on the write-back cycle. Each run is judged by the retire stream and the final register values, compared with a sequential interpretation of the same program.

// File: rtl/ooo_pkg.sv
package ooo_pkg;
  parameter int DATA_W  = 16;
  parameter int REG_AW  = 3;
  parameter int INSTR_W = 16;
  parameter int SHAMT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
    OP_XOR = 3'd4, OP_SHL = 3'd5, OP_SHR = 3'd6, OP_LDI = 3'd7
  } op_e;

  function automatic logic [DATA_W-1:0] alu_calc(op_e op, logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_SHL:  return a << b[SHAMT_W-1:0];
      OP_SHR:  return a >> b[SHAMT_W-1:0];
      default: return a;  // immediate already placed in a
    endcase
  endfunction
endpackage

// File: rtl/ooo_alu.sv
module ooo_alu import ooo_pkg::*; #(
  parameter int LAT   = 3,
  parameter int TAG_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [TAG_W-1:0]  tag_in,
  output logic              free,
  output logic              done,
  output logic [TAG_W-1:0]  tag_out,
  output logic [DATA_W-1:0] res
);
  localparam int CW = $clog2(LAT + 1);

  logic              busy;
  logic [CW-1:0]     cnt;
  op_e               op_q;
  logic [DATA_W-1:0] a_q, b_q;

  assign done    = busy && (cnt == '0);
  assign free    = !busy || done;
  assign tag_out = busy ? tag_out_q : '0;
  assign res     = alu_calc(op_q, a_q, b_q);

  logic [TAG_W-1:0] tag_out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      op_q      <= OP_ADD;
      a_q       <= '0;
      b_q       <= '0;
      tag_out_q <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= CW'(LAT - 1);
      op_q      <= op;
      a_q       <= a;
      b_q       <= b;
      tag_out_q <= tag_in;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ooo_pick.sv
module ooo_pick #(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic [PW-1:0]    head,
  input  logic [DEPTH-1:0] cand,
  output logic             first_v,
  output logic [PW-1:0]    first_idx,
  output logic             second_v,
  output logic [PW-1:0]    second_idx
);
  always_comb begin
    first_v    = 1'b0;
    first_idx  = '0;
    second_v   = 1'b0;
    second_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = head + PW'(k);
      if (cand[idx]) begin
        if (!first_v) begin
          first_v   = 1'b1;
          first_idx = idx;
        end else if (!second_v) begin
          second_v   = 1'b1;
          second_idx = idx;
        end
      end
    end
  end
endmodule

// File: rtl/ooo_core.sv
module ooo_core import ooo_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int LAT   = 3,
  parameter int PC_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [INSTR_W-1:0]         in_instr,
  output logic [PC_W-1:0]            pc,
  output logic                       retire_valid,
  output logic [REG_AW-1:0]          retire_rd,
  output logic [DATA_W-1:0]          retire_data,
  output logic [(2**REG_AW)*DATA_W-1:0] regs_flat
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int NREG = 2 ** REG_AW;
  localparam int NU   = 2;

  // reorder buffer storage
  logic [DEPTH-1:0]  e_act, e_done, e_iss, e_r1, e_r2;
  logic [REG_AW-1:0] e_rd  [DEPTH];
  op_e               e_op  [DEPTH];
  logic [DATA_W-1:0] e_v1  [DEPTH];
  logic [DATA_W-1:0] e_v2  [DEPTH];
  logic [DATA_W-1:0] e_res [DEPTH];
  logic [PW-1:0]     e_t1  [DEPTH];
  logic [PW-1:0]     e_t2  [DEPTH];
  logic [DATA_W-1:0] rf    [NREG];
  logic [PW-1:0]     head, tail;
  logic [CW-1:0]     count;

  // execution unit wires
  logic [NU-1:0]     u_free, u_done, u_start;
  logic [PW-1:0]     u_tag [NU];
  logic [PW-1:0]     u_idx [NU];
  logic [DATA_W-1:0] u_res [NU];

  // decode
  op_e               d_op;
  logic [REG_AW-1:0] d_rd;
  logic [REG_AW-1:0] d_src [2];
  logic [DATA_W-1:0] d_val [2];
  logic              d_rdy [2];
  logic [PW-1:0]     d_tag [2];
  logic              accept, retire;

  assign d_op     = op_e'(in_instr[15:13]);
  assign d_rd     = in_instr[12:10];
  assign d_src[0] = in_instr[9:7];
  assign d_src[1] = in_instr[6:4];
  assign in_ready = (count != CW'(DEPTH));
  assign accept   = in_valid && in_ready;
  assign retire   = e_act[head] && e_done[head];

  assign retire_valid = retire;
  assign retire_rd    = e_rd[head];
  assign retire_data  = e_res[head];

  for (genvar r = 0; r < NREG; r++) begin : g_regs
    assign regs_flat[r*DATA_W +: DATA_W] = rf[r];
  end

  // source lookup: youngest older producer, else register file
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      logic          found;
      logic [PW-1:0] ftag;
      found = 1'b0;
      ftag  = '0;
      for (int k = 0; k < DEPTH; k++) begin
        logic [PW-1:0] idx;
        idx = head + PW'(k);
        if ((CW'(k) < count) && (e_rd[idx] == d_src[s])) begin
          found = 1'b1;
          ftag  = idx;
        end
      end
      d_tag[s] = ftag;
      d_rdy[s] = 1'b1;
      d_val[s] = rf[d_src[s]];
      if (found) begin
        if (e_done[ftag])                       d_val[s] = e_res[ftag];
        else if (u_done[0] && u_tag[0] == ftag) d_val[s] = u_res[0];
        else if (u_done[1] && u_tag[1] == ftag) d_val[s] = u_res[1];
        else                                    d_rdy[s] = 1'b0;
      end
    end
    if (d_op == OP_LDI) begin
      d_val[0] = DATA_W'(in_instr[9:0]);
      d_rdy[0] = 1'b1;
      d_rdy[1] = 1'b1;
    end
  end

  // issue selection
  logic [DEPTH-1:0] cand;
  logic             p1_v, p2_v;
  logic [PW-1:0]    p1_idx, p2_idx;
  assign cand = e_act & ~e_iss & e_r1 & e_r2;

  ooo_pick #(.DEPTH(DEPTH), .PW(PW)) i_pick (
    .head(head), .cand(cand),
    .first_v(p1_v), .first_idx(p1_idx),
    .second_v(p2_v), .second_idx(p2_idx)
  );

  assign u_start[0] = u_free[0] && p1_v;
  assign u_idx[0]   = p1_idx;
  assign u_start[1] = u_free[1] && (u_free[0] ? p2_v : p1_v);
  assign u_idx[1]   = u_free[0] ? p2_idx : p1_idx;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    ooo_alu #(.LAT(LAT), .TAG_W(PW)) i_alu (
      .clk(clk), .rst(rst), .start(u_start[u]),
      .op(e_op[u_idx[u]]), .a(e_v1[u_idx[u]]), .b(e_v2[u_idx[u]]),
      .tag_in(u_idx[u]), .free(u_free[u]), .done(u_done[u]),
      .tag_out(u_tag[u]), .res(u_res[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_act <= '0; e_done <= '0; e_iss <= '0; e_r1 <= '0; e_r2 <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_rd[i] <= '0; e_op[i] <= OP_ADD; e_v1[i] <= '0; e_v2[i] <= '0;
        e_res[i] <= '0; e_t1[i] <= '0; e_t2[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
      pc    <= '0;
    end else begin
      // write-back and broadcast
      for (int u = 0; u < NU; u++) begin
        if (u_done[u]) begin
          e_done[u_tag[u]] <= 1'b1;
          e_res[u_tag[u]]  <= u_res[u];
          for (int i = 0; i < DEPTH; i++) begin
            if (e_act[i] && !e_r1[i] && e_t1[i] == u_tag[u]) begin
              e_v1[i] <= u_res[u];
              e_r1[i] <= 1'b1;
            end
            if (e_act[i] && !e_r2[i] && e_t2[i] == u_tag[u]) begin
              e_v2[i] <= u_res[u];
              e_r2[i] <= 1'b1;
            end
          end
        end
        if (u_start[u]) e_iss[u_idx[u]] <= 1'b1;
      end
      // in-order retirement
      if (retire) begin
        rf[e_rd[head]] <= e_res[head];
        e_act[head]    <= 1'b0;
        head           <= head + 1'b1;
      end
      // allocation at the tail
      if (accept) begin
        e_act[tail]  <= 1'b1;
        e_done[tail] <= 1'b0;
        e_iss[tail]  <= 1'b0;
        e_rd[tail]   <= d_rd;
        e_op[tail]   <= d_op;
        e_v1[tail]   <= d_val[0];
        e_v2[tail]   <= d_val[1];
        e_r1[tail]   <= d_rdy[0];
        e_r2[tail]   <= d_rdy[1];
        e_t1[tail]   <= d_tag[0];
        e_t2[tail]   <= d_tag[1];
        tail         <= tail + 1'b1;
        pc           <= pc + 1'b1;
      end
      count <= count + CW'(accept) - CW'(retire);
    end
  end
endmodule

// File: rtl/ooo_core_check.sv
module ooo_core_check #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3,
  parameter int PC_W  = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [PC_W-1:0] pc,
  input logic            retire_valid,
  input logic [CW-1:0]   count,
  input logic [PW-1:0]   head,
  input logic            iss0,
  input logic            iss1,
  input logic [PW-1:0]   idx0,
  input logic [PW-1:0]   idx1
);
  logic [PW-1:0] age0, age1;
  assign age0 = idx0 - head;
  assign age1 = idx1 - head;

  a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |-> !in_ready);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (pc == $past(pc) + 1'b1));

  a_r2_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(pc));

  a_r4_head_step: assert property (@(posedge clk) disable iff (rst)
    retire_valid |=> (head == $past(head) + 1'b1));

  a_r4_retire_occupied: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> (count != '0));

  a_r9_unit0_oldest: assert property (@(posedge clk) disable iff (rst)
    (iss0 && iss1) |-> (age0 < age1));

  always_comb begin
    if (!rst) a_r2_count_bound: assert (count <= CW'(DEPTH));
  end
endmodule

bind ooo_core ooo_core_check #(.DEPTH(DEPTH), .PW(PW), .CW(CW), .PC_W(PC_W)) i_check (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .pc(pc),
  .retire_valid(retire_valid), .count(count), .head(head),
  .iss0(u_start[0]), .iss1(u_start[1]), .idx0(u_idx[0]), .idx1(u_idx[1])
);

// File: tb/test_ooo_core.sv
module test_ooo_core;
  localparam int DEPTH = 4;
  localparam int LAT   = 3;
  localparam int MAXP  = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [15:0]  in_instr = '0;
  logic [7:0]   pc;
  logic         retire_valid;
  logic [2:0]   retire_rd;
  logic [15:0]  retire_data;
  logic [127:0] regs_flat;

  ooo_core #(.DEPTH(DEPTH), .LAT(LAT), .PC_W(8)) i_ooo_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .pc(pc), .retire_valid(retire_valid),
    .retire_rd(retire_rd), .retire_data(retire_data), .regs_flat(regs_flat)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] prog    [MAXP];
  int          gap     [MAXP];
  int          acc_cyc [MAXP];
  int          ret_cyc [MAXP];
  logic [2:0]  exp_rd  [MAXP];
  logic [15:0] exp_val [MAXP];
  logic [15:0] ref_rf  [8];
  int plen = 0, ridx = 0;
  bit mon_en = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // retire stream monitor
  always @(negedge clk) begin
    if (mon_en && retire_valid) begin
      if (ridx < plen) begin
        check(retire_rd == exp_rd[ridx] && retire_data == exp_val[ridx], "R4 R5 retire",
              {13'd0, retire_rd, retire_data}, {13'd0, exp_rd[ridx], exp_val[ridx]});
        ret_cyc[ridx] = cyc;
        ridx++;
      end else begin
        check(1'b0, "R4 extra retire", {16'd0, retire_data}, 32'd0);
      end
    end
  end

  function automatic logic [15:0] enc(input int op, input int rd, input int s1, input int s2);
    return {op[2:0], rd[2:0], s1[2:0], s2[2:0], 4'b0};
  endfunction
  function automatic logic [15:0] ldi(input int rd, input int imm);
    return {3'd7, rd[2:0], imm[9:0]};
  endfunction

  // sequential interpretation per R3
  task automatic build_ref();
    for (int r = 0; r < 8; r++) ref_rf[r] = '0;
    for (int i = 0; i < plen; i++) begin
      logic [15:0] w, a, b, v;
      w = prog[i];
      a = ref_rf[w[9:7]];
      b = ref_rf[w[6:4]];
      case (w[15:13])
        3'd0: v = a + b;
        3'd1: v = a - b;
        3'd2: v = a & b;
        3'd3: v = a | b;
        3'd4: v = a ^ b;
        3'd5: v = a << b[3:0];
        3'd6: v = a >> b[3:0];
        default: v = {6'd0, w[9:0]};
      endcase
      ref_rf[w[12:10]] = v;
      exp_rd[i]  = w[12:10];
      exp_val[i] = v;
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_prog();
    plen = 0;
    for (int i = 0; i < MAXP; i++) gap[i] = 0;
  endtask

  task automatic add(input logic [15:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic run_prog(input string tag);
    int t;
    do_reset();
    build_ref();
    ridx = 0;
    mon_en = 1;
    for (int i = 0; i < plen; i++) begin
      in_valid = 1'b0;
      repeat (gap[i]) @(negedge clk);
      in_instr = prog[i];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      acc_cyc[i] = cyc;
      @(negedge clk);
    end
    in_valid = 1'b0;
    t = 0;
    while (ridx < plen && t < 400) begin
      @(negedge clk);
      t++;
    end
    check(ridx == plen, {"R4 all retired ", tag}, ridx, plen);
    repeat (2) @(negedge clk);
    mon_en = 0;
    check(pc == 8'(plen), {"R2 pc count ", tag}, pc, plen);
    for (int r = 0; r < 8; r++)
      check(regs_flat[r*16 +: 16] == ref_rf[r], {"R5 register ", tag},
            regs_flat[r*16 +: 16], ref_rf[r]);
  endtask

  task automatic t_reset();
    do_reset();
    check(pc == 0, "R1 pc", pc, 0);
    check(regs_flat == '0, "R1 regs", regs_flat[31:0], 0);
    check(!retire_valid, "R1 retire_valid", retire_valid, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_ops();  // R3
    clear_prog();
    add(ldi(1, 1000)); add(ldi(2, 3));
    add(enc(0, 3, 1, 2)); add(enc(1, 4, 2, 1)); add(enc(2, 5, 1, 2));
    add(enc(3, 6, 1, 2)); add(enc(4, 7, 1, 2)); add(enc(5, 0, 1, 2));
    add(enc(6, 1, 1, 2));
    gap[4] = 2;
    run_prog("R3 ops");
  endtask

  task automatic t_latency();  // R7
    clear_prog();
    add(ldi(5, 77));
    run_prog("R7");
    check(ret_cyc[0] - acc_cyc[0] == LAT + 2, "R7 latency", ret_cyc[0] - acc_cyc[0], LAT + 2);
  endtask

  task automatic t_dual();  // R8
    clear_prog();
    add(ldi(1, 10)); add(ldi(2, 20));
    run_prog("R8");
    check(ret_cyc[0] - acc_cyc[0] == LAT + 2, "R8 first", ret_cyc[0] - acc_cyc[0], LAT + 2);
    check(ret_cyc[1] - acc_cyc[0] == LAT + 3, "R8 second", ret_cyc[1] - acc_cyc[0], LAT + 3);
  endtask

  task automatic t_burst();  // R9
    clear_prog();
    add(ldi(1, 1)); add(ldi(2, 2)); add(ldi(3, 3)); add(ldi(4, 4));
    run_prog("R9");
    check(ret_cyc[0] - acc_cyc[0] == LAT + 2, "R9 slot0", ret_cyc[0] - acc_cyc[0], LAT + 2);
    check(ret_cyc[1] - acc_cyc[0] == LAT + 3, "R9 slot1", ret_cyc[1] - acc_cyc[0], LAT + 3);
    check(ret_cyc[2] - acc_cyc[0] == 2*LAT + 2, "R9 slot2", ret_cyc[2] - acc_cyc[0], 2*LAT + 2);
    check(ret_cyc[3] - acc_cyc[0] == 2*LAT + 3, "R9 slot3", ret_cyc[3] - acc_cyc[0], 2*LAT + 3);
  endtask

  task automatic t_deps();  // R5
    clear_prog();
    add(ldi(1, 5)); add(ldi(1, 9)); add(enc(0, 2, 1, 1)); add(enc(0, 3, 2, 1));
    add(ldi(4, 2)); add(enc(4, 5, 3, 4)); add(enc(1, 6, 5, 2));
    run_prog("R5 deps");
  endtask

  task automatic t_full();  // R2
    clear_prog();
    add(ldi(1, 1));
    for (int i = 0; i < 6; i++) add(enc(0, 1, 1, 1));
    run_prog("R2 full");
    check(acc_cyc[3] - acc_cyc[0] == 3, "R2 fill", acc_cyc[3] - acc_cyc[0], 3);
    check(acc_cyc[4] - acc_cyc[0] == LAT + 3, "R2 back-pressure",
          acc_cyc[4] - acc_cyc[0], LAT + 3);
  endtask

  task automatic t_bypass();  // R6
    for (int g = 0; g <= LAT + 3; g++) begin
      clear_prog();
      add(ldi(1, 11 + g)); add(enc(0, 2, 1, 1)); add(enc(1, 3, 2, 1));
      gap[1] = g;
      run_prog("R6 bypass");
    end
  endtask

  initial begin
    t_reset();
    t_ops();
    t_latency();
    t_dual();
    t_burst();
    t_deps();
    t_full();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule